// File: doc/BRIEF.md
# Redundant Thread Lag Buffer and Result Checker

This block sits between two copies of one program running on the same core: a leading copy and a trailing copy that re-executes the same instruction stream later. Each instruction the leading copy retires is pushed into a circular buffer as one entry. An entry holds the instruction address, the address of the next instruction, the destination register index, a flag that marks whether the instruction produces a result, and the result itself. The trailing copy reads entries in the order they were written. It uses each entry as a ready-made branch outcome and value prediction, so it needs no predictor of its own.

When the trailing copy finishes an instruction, it hands its own next address and result back to the block. The block compares them with the oldest entry. Any difference is treated as a transient fault. On a fault the block empties the buffer, raises a recovery pulse, and keeps the address of the offending instruction. The surrounding core then restarts both copies from the trailing copy's last retired state.

The buffer keeps a minimum number of entries between the two copies, so the two executions of one instruction are always separated in time. The only exception is a final drain after the leading copy has stopped. A fault can stay undetected for at most as many retirements as the buffer can hold.

Top module: `redundant_lag_checker`

## Requirements
- R1: After reset the buffer is empty. `lead_ready` is 1, and `pred_valid`, `recover` and `fault_pc` are all 0.
- R2: A leading commit is taken on a rising edge where `lead_valid` and `lead_ready` are both 1. Taken commits come out on the `pred_*` outputs in the same order they were taken.
- R3: `lead_ready` is 0 while the buffer holds DEPTH entries. It is also 0 during the cycle in which `recover` is 1.
- R4: `pred_valid` is 1 only when the buffer holds at least DELAY_MIN entries, or when `lead_done` is 1 and the buffer holds at least one entry.
- R5: While `pred_valid` is 1, the `pred_pc`, `pred_npc`, `pred_rd`, `pred_rv` and `pred_res` outputs show the fields of the oldest entry.
- R6: A check is taken on a rising edge where `chk_valid` and `chk_ready` are both 1. `chk_ready` equals `pred_valid`. A taken check removes the oldest entry. The check is a mismatch when `chk_npc` differs from the entry's next address.
- R7: The result is compared only when the entry's result flag (`pred_rv`) is 1. When the flag is 0, `chk_res` has no effect.
- R8: A mismatching check makes `recover` equal 1 for exactly the following cycle. In that same cycle the buffer is empty, and any leading commit offered on the mismatch edge is dropped.
- R9: `fault_pc` holds the instruction address of the last mismatching entry. It keeps that value until the next mismatch.
- R10: A single-bit corruption in either compared field of any buffered entry is reported on the check that consumes that entry. This bounds detection to at most DEPTH retirements after the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_valid | input | 1 | Leading commit offered |
| lead_ready | output | 1 | Buffer can take a commit |
| lead_pc | input | 32 | Committed instruction address |
| lead_npc | input | 32 | Next instruction address |
| lead_rd | input | 5 | Destination register index |
| lead_rv | input | 1 | Instruction produces a result |
| lead_res | input | 32 | Result value |
| lead_done | input | 1 | Leading copy stopped; lets the buffer drain below the minimum gap |
| pred_valid | output | 1 | Oldest entry available to the trailing copy |
| pred_pc | output | 32 | Oldest entry instruction address |
| pred_npc | output | 32 | Oldest entry next address (control prediction) |
| pred_rd | output | 5 | Oldest entry destination index |
| pred_rv | output | 1 | Oldest entry result flag |
| pred_res | output | 32 | Oldest entry result (value prediction) |
| chk_valid | input | 1 | Trailing copy presents its outcome |
| chk_ready | output | 1 | Check may be taken (equals pred_valid) |
| chk_npc | input | 32 | Trailing computed next address |
| chk_res | input | 32 | Trailing computed result |
| recover | output | 1 | One-cycle fault and recovery pulse |
| fault_pc | output | 32 | Address of the last mismatching instruction |

## Verification
The assertions assume that `lead_done` is raised only after the last leading commit and stays high during the drain. They also assume the trailing copy keeps `chk_valid` low when it has nothing to report. The stimulus never offers a check while `chk_ready` is 0 and only offers commits in patterns where the expected `lead_ready` value is known. Every test starts from an empty buffer, either after reset or after a fault flush.

// File: rtl/lagchk_pkg.sv
package lagchk_pkg;
  localparam int PC_W  = 32;
  localparam int DAT_W = 32;
  localparam int IDX_W = 5;

  typedef struct packed {
    logic [PC_W-1:0]  pc;
    logic [PC_W-1:0]  npc;
    logic [IDX_W-1:0] rd;
    logic             rv;
    logic [DAT_W-1:0] res;
  } lag_entry_t;
endpackage

// File: rtl/lagchk_ring.sv
module lagchk_ring
  import lagchk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  lag_entry_t      wr_data,
  input  logic            rd_en,
  input  logic            flush,
  output lag_entry_t      rd_data,
  output logic [CNTW-1:0] count
);
  localparam logic [PTRW-1:0] LAST_P = PTRW'(DEPTH - 1);
  localparam logic [CNTW-1:0] FULL_C = CNTW'(DEPTH);

  lag_entry_t      mem [DEPTH];
  logic [PTRW-1:0] wp, rp;
  logic [CNTW-1:0] cnt_nxt;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    cnt_nxt = count;
    case ({wr_en, rd_en})
      2'b10:   cnt_nxt = count + 1'b1;
      2'b01:   cnt_nxt = count - 1'b1;
      default: cnt_nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_en) wp <= bump(wp);
      if (rd_en) rp <= bump(rp);
      count <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) mem[wp] <= wr_data;
  end

  assign rd_data = mem[rp];

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (count < FULL_C));
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (count != '0));
endmodule

// File: rtl/lagchk_cmp.sv
module lagchk_cmp
  import lagchk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  lag_entry_t       head,
  input  logic [PC_W-1:0]  act_npc,
  input  logic [DAT_W-1:0] act_res,
  output logic             mismatch,
  output logic             recover,
  output logic [PC_W-1:0]  fault_pc
);
  logic npc_bad, res_bad;

  assign npc_bad  = (act_npc != head.npc);
  assign res_bad  = head.rv && (act_res != head.res);
  assign mismatch = fire && (npc_bad || res_bad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      recover  <= 1'b0;
      fault_pc <= '0;
    end else begin
      recover <= mismatch;
      if (mismatch) fault_pc <= head.pc;
    end
  end

  p_hold_fault_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mismatch |=> $stable(fault_pc));
endmodule

// File: rtl/redundant_lag_checker.sv
module redundant_lag_checker
  import lagchk_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int DELAY_MIN = 3,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lead_valid,
  output logic             lead_ready,
  input  logic [PC_W-1:0]  lead_pc,
  input  logic [PC_W-1:0]  lead_npc,
  input  logic [IDX_W-1:0] lead_rd,
  input  logic             lead_rv,
  input  logic [DAT_W-1:0] lead_res,
  input  logic             lead_done,
  output logic             pred_valid,
  output logic [PC_W-1:0]  pred_pc,
  output logic [PC_W-1:0]  pred_npc,
  output logic [IDX_W-1:0] pred_rd,
  output logic             pred_rv,
  output logic [DAT_W-1:0] pred_res,
  input  logic             chk_valid,
  output logic             chk_ready,
  input  logic [PC_W-1:0]  chk_npc,
  input  logic [DAT_W-1:0] chk_res,
  output logic             recover,
  output logic [PC_W-1:0]  fault_pc
);
  localparam logic [CNTW-1:0] FULL_C = CNTW'(DEPTH);
  localparam logic [CNTW-1:0] MIN_C  = CNTW'(DELAY_MIN);

  lag_entry_t      wr_ent, head;
  logic [CNTW-1:0] count;
  logic            lead_fire, chk_fire, mismatch;

  assign wr_ent     = '{pc: lead_pc, npc: lead_npc, rd: lead_rd, rv: lead_rv, res: lead_res};
  assign lead_ready = (count < FULL_C) && !recover;
  assign lead_fire  = lead_valid && lead_ready;
  assign pred_valid = (count >= MIN_C) || (lead_done && (count != '0));
  assign chk_ready  = pred_valid;
  assign chk_fire   = chk_valid && chk_ready;

  assign pred_pc  = head.pc;
  assign pred_npc = head.npc;
  assign pred_rd  = head.rd;
  assign pred_rv  = head.rv;
  assign pred_res = head.res;

  lagchk_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(lead_fire), .wr_data(wr_ent),
    .rd_en(chk_fire), .flush(mismatch), .rd_data(head), .count(count)
  );

  lagchk_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .fire(chk_fire), .head(head),
    .act_npc(chk_npc), .act_res(chk_res), .mismatch(mismatch),
    .recover(recover), .fault_pc(fault_pc)
  );

  p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_C) |-> !lead_ready);
  p_min_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fire |-> ((count >= MIN_C) || lead_done));
  p_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    recover |-> $past(chk_fire));
  p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> !recover);
  p_flushed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    recover |-> (count == '0));
  p_fault_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recover |-> (fault_pc == $past(pred_pc)));
endmodule

// File: tb/sim_redundant_lag_checker.sv
module sim_redundant_lag_checker;
  localparam int D = 8;
  localparam int M = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lead_valid = 0, lead_rv = 0, lead_done = 0, chk_valid = 0;
  logic [31:0] lead_pc = 0, lead_npc = 0, lead_res = 0, chk_npc = 0, chk_res = 0;
  logic [4:0]  lead_rd = 0;
  logic        lead_ready, pred_valid, pred_rv, chk_ready, recover;
  logic [31:0] pred_pc, pred_npc, pred_res, fault_pc;
  logic [4:0]  pred_rd;

  int n_chk = 0, n_err = 0;
  logic [31:0] e_pc [D], e_npc [D], e_res [D];
  logic        e_rv [D];

  always #5 clk = ~clk;

  redundant_lag_checker #(.DEPTH(D), .DELAY_MIN(M)) u0 (
    .clk(clk), .rst_n(rst_n), .lead_valid(lead_valid), .lead_ready(lead_ready),
    .lead_pc(lead_pc), .lead_npc(lead_npc), .lead_rd(lead_rd), .lead_rv(lead_rv),
    .lead_res(lead_res), .lead_done(lead_done), .pred_valid(pred_valid),
    .pred_pc(pred_pc), .pred_npc(pred_npc), .pred_rd(pred_rd), .pred_rv(pred_rv),
    .pred_res(pred_res), .chk_valid(chk_valid), .chk_ready(chk_ready),
    .chk_npc(chk_npc), .chk_res(chk_res), .recover(recover), .fault_pc(fault_pc)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic commit(input logic [31:0] pc, npc, input logic rv, input logic [31:0] res,
                        input logic exp_rdy, input string req);
    @(negedge clk);
    lead_valid = 1; lead_pc = pc; lead_npc = npc; lead_rv = rv; lead_res = res;
    lead_rd = pc[6:2];
    #1 chk(lead_ready === exp_rdy, req, 32'(lead_ready), 32'(exp_rdy));
    @(posedge clk); #1 lead_valid = 0;
  endtask

  task automatic consume(input int i, input logic [31:0] npc, res, input logic exp_rec, input string req);
    @(negedge clk); #1
    chk(pred_valid === 1'b1, req, 32'(pred_valid), 1);
    chk(pred_pc === e_pc[i] && pred_npc === e_npc[i] && pred_rv === e_rv[i] &&
        pred_rd === e_pc[i][6:2] && (!e_rv[i] || pred_res === e_res[i]),
        req, pred_pc, e_pc[i]);
    chk_valid = 1; chk_npc = npc; chk_res = res;
    @(posedge clk); #1 chk_valid = 0;
    chk(recover === exp_rec, req, 32'(recover), 32'(exp_rec));
  endtask

  task automatic fill(input int n, input int seed_base);
    for (int i = 0; i < n; i++) begin
      e_pc[i]  = 32'h1000 + 32'(seed_base * 64 + i * 4);
      e_npc[i] = $urandom;
      e_rv[i]  = 1'b1;
      e_res[i] = $urandom;
      commit(e_pc[i], e_npc[i], e_rv[i], e_res[i], 1'b1, "R2");
    end
  endtask

  task automatic t_reset();
    rst_n = 0; lead_done = 0;
    repeat (2) @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(lead_ready === 1 && pred_valid === 0 && recover === 0, "R1", 32'(pred_valid), 0);
    chk(fault_pc === 0, "R1 fault_pc", fault_pc, 0);
  endtask

  task automatic t_gap_and_full();
    lead_done = 0;
    for (int i = 0; i < D; i++) begin
      e_pc[i] = 32'h2000 + 32'(i * 4); e_npc[i] = e_pc[i] + 4;
      e_rv[i] = 1'b1; e_res[i] = 32'(i * 7);
      commit(e_pc[i], e_npc[i], 1'b1, e_res[i], 1'b1, "R2");
      @(negedge clk); #1
      chk(pred_valid === (i + 1 >= M), "R4 gap", 32'(pred_valid), 32'(i + 1 >= M));
    end
    commit(32'hdead, 0, 0, 0, 1'b0, "R3 full stall");
    lead_done = 1;
    for (int i = 0; i < D; i++) consume(i, e_npc[i], e_res[i], 1'b0, "R5 R2 clean replay");
    @(negedge clk); #1 chk(pred_valid === 0, "R4 drained", 32'(pred_valid), 0);
  endtask

  task automatic t_rv_ignore();
    lead_done = 1;
    e_pc[0] = 32'h3000; e_npc[0] = 32'h3004; e_rv[0] = 0; e_res[0] = 32'h55;
    commit(e_pc[0], e_npc[0], 1'b0, e_res[0], 1'b1, "R7");
    consume(0, e_npc[0], 32'hffff_0000, 1'b0, "R7 result ignored");
    chk(fault_pc === 0, "R7 no fault", fault_pc, 0);
  endtask

  task automatic t_npc_fault();
    lead_done = 0;
    fill(M, 1);
    @(negedge clk);
    lead_valid = 1; lead_pc = 32'h9999; lead_npc = 0; lead_rv = 0;
    #1 chk(pred_valid === 1 && pred_pc === e_pc[0], "R5", pred_pc, e_pc[0]);
    chk_valid = 1; chk_npc = e_npc[0] ^ 32'h10; chk_res = e_res[0];
    @(posedge clk); #1 chk_valid = 0; lead_valid = 0;
    chk(recover === 1, "R6 npc mismatch", 32'(recover), 1);
    chk(lead_ready === 0, "R3 stall in recover", 32'(lead_ready), 0);
    chk(fault_pc === e_pc[0], "R9", fault_pc, e_pc[0]);
    lead_done = 1; #1
    chk(pred_valid === 0, "R8 flushed, commit dropped", 32'(pred_valid), 0);
    @(posedge clk); #1
    chk(recover === 0, "R8 one-cycle pulse", 32'(recover), 0);
    chk(fault_pc === e_pc[0], "R9 hold", fault_pc, e_pc[0]);
  endtask

  task automatic t_corrupt(input int j, input int bitn, input bit in_res);
    lead_done = 0;
    fill(D, 2 + j);
    commit(32'hbeef, 0, 0, 0, 1'b0, "R3");
    lead_done = 1;
    for (int i = 0; i <= j; i++) begin
      if (i < j) consume(i, e_npc[i], e_res[i], 1'b0, "R10 no false alarm");
      else if (in_res) consume(i, e_npc[i], e_res[i] ^ (32'h1 << bitn), 1'b1, "R10 result flip");
      else consume(i, e_npc[i] ^ (32'h1 << bitn), e_res[i], 1'b1, "R10 npc flip");
    end
    chk(fault_pc === e_pc[j], "R9 R10 fault pc", fault_pc, e_pc[j]);
    @(posedge clk); #1
    chk(pred_valid === 0 && recover === 0, "R8 empty after fault", 32'(pred_valid), 0);
  endtask

  initial begin
    void'($urandom(17));
    t_reset();
    t_gap_and_full();
    t_rv_ignore();
    t_npc_fault();
    t_corrupt(0, 0, 1'b1);
    t_corrupt(D - 1, 31, 1'b1);
    t_corrupt(3, 5, 1'b0);
    t_corrupt(5, 17, 1'b1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule